// File: doc/BRIEF.md
# Guarded Relay Command Latch

This block receives relay commands for one switching card over a serial chain and drives that card's relay enables. A 24-bit shift register collects the command. Its most significant bit is presented on a serial output, so several cards can share one serial interface in a daisy chain. The active-low latch strobe does two jobs. It gates shifting, and its rising edge copies the shifted word into a staging register. The relay enable flops are kept separate from the shift path, so shifting never moves a relay.

While the strobe is low, every relay enable is held off. The staged command is applied only after a filtered copy of the strobe has seen the strobe high for a programmable settling time, which gives relays time to open. A low pulse shorter than the filter time is not treated as a new command.

Before a command is applied it is checked. No more than one relay may be on in the input layer, and no more than one in the output layer. An output-layer relay may not be enabled while another card reports its own output relay active. A command that fails the check forces all enables off and asserts the pull-down for a shared active-low master clear. That fault stays latched until a later strobe delivers a command that passes. Whenever the shared clear line is seen low, all enables drop and stay off until the next command is applied.

Top module: `relay_cmd_guard`

## Requirements
- R1: Serial data is shifted MSB first on each rising serial clock edge while the strobe is low. The serial output carries the register's bit 23, which is the bit shifted in 24 edges earlier.
- R2: Serial clock edges while the strobe is high are ignored. Relay outputs and the serial output do not change.
- R3: Within 3 system clock cycles after the strobe falls, all relay outputs are off.
- R4: A command is applied only after the strobe has been high for SETTLE_CYC synchronized cycles. Before that, the outputs stay off.
- R5: A strobe low pulse shorter than FILT_CYC cycles turns the outputs off, and no command is reapplied afterwards.
- R6: Command field layout: bits 9..0 drive input relays 9..0, bits 13..10 drive output relays 3..0, and bit 14 drives the current-channel enable. Bits 23..15 are ignored.
- R7: A command with two or more input-layer bits set leaves all outputs off and asserts the clear pull-down.
- R8: A command with two or more output-layer bits set leaves all outputs off and asserts the clear pull-down.
- R9: A command with any output-layer bit set is rejected as a fault when the other-card-active input is high. A command with no output-layer bit set is accepted in that case.
- R10: While the master clear input is low, all outputs are off. They remain off after it returns high until the next command is applied. A command whose apply moment falls inside the clear window stays off and raises no fault.
- R11: A fault persists until a later strobe applies a passing command. That command then clears the pull-down and drives the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (sampled) |
| ser_dat_i | input | 1 | Serial data in |
| ser_dat_o | output | 1 | Serial data out to the next card |
| latch_n_i | input | 1 | Latch strobe, active low |
| mclr_n_i | input | 1 | Shared master clear line, read side, active low |
| other_active_i | input | 1 | Another card has an output relay on |
| mclr_pull_o | output | 1 | Pull the shared clear low (fault latched) |
| in_relay_o | output | 10 | Input-layer relay enables |
| out_relay_o | output | 4 | Output-layer relay enables |
| cur_relay_o | output | 1 | Current-channel enable |

## Verification
Two events can land in the same cycle: the apply pulse from the strobe filter, and a clear request from the shared master clear line or the other-card flag. The bench holds the master clear low across the whole settling window of a valid command, so the clear is active exactly when the apply pulse fires. The expected result is that the outputs stay off, no fault is latched, and nothing turns on after the line is released. The other-card flag is raised before a command containing an output-layer bit, so the acceptance check and the overlap check are judged on the same apply pulse.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int CMD_W   = 24;
  localparam int IN_N    = 10;
  localparam int OUT_N   = 4;
  localparam int IN_LSB  = 0;
  localparam int OUT_LSB = IN_LSB + IN_N;
  localparam int CUR_BIT = OUT_LSB + OUT_N;

  typedef struct packed {
    logic             cur;
    logic [OUT_N-1:0] outl;
    logic [IN_N-1:0]  inl;
  } relay_cmd_t;

  function automatic int unsigned ones(input logic [IN_N-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < IN_N; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/rcg_sync.sv
module rcg_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rcg_shift.sv
module rcg_shift
  import rcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s_i,
  input  logic             sdi_s_i,
  input  logic             stb_s_i,
  output logic             sdo_o,
  output logic [CMD_W-1:0] stage_o
);
  logic             sclk_d_q, stb_d_q;
  logic [CMD_W-1:0] sr_q, sr_n, stage_q, stage_n;
  logic             shift_en, cap_en;

  assign shift_en = sclk_s_i && !sclk_d_q && !stb_s_i;
  assign cap_en   = stb_s_i && !stb_d_q;

  always_comb begin
    sr_n    = sr_q;
    stage_n = stage_q;
    if (shift_en) sr_n = {sr_q[CMD_W-2:0], sdi_s_i};
    if (cap_en)   stage_n = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      stb_d_q  <= 1'b1;
      sr_q     <= '0;
      stage_q  <= '0;
    end else begin
      sclk_d_q <= sclk_s_i;
      stb_d_q  <= stb_s_i;
      sr_q     <= sr_n;
      stage_q  <= stage_n;
    end
  end

  assign sdo_o   = sr_q[CMD_W-1];
  assign stage_o = stage_q;

  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_s_i |=> $stable(sr_q));
endmodule

// File: rtl/rcg_strobe_filter.sv
module rcg_strobe_filter #(
  parameter int SETTLE_CYC = 3_000_000,
  parameter int FILT_CYC   = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_s_i,
  output logic load_o
);
  localparam int MAXC  = (SETTLE_CYC > FILT_CYC) ? SETTLE_CYC : FILT_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SET_LIM  = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] FILT_LIM = CNT_W'(FILT_CYC - 1);

  logic             filt_q, filt_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             load_n;

  always_comb begin
    filt_n = filt_q;
    cnt_n  = '0;
    load_n = 1'b0;
    if (filt_q) begin
      if (!stb_s_i) begin
        if (cnt_q == FILT_LIM) filt_n = 1'b0;
        else                   cnt_n  = cnt_q + 1'b1;
      end
    end else begin
      if (stb_s_i) begin
        if (cnt_q == SET_LIM) begin
          filt_n = 1'b1;
          load_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_n;
      cnt_q  <= cnt_n;
    end
  end

  assign load_o = load_n;

  // R4
  load_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> stb_s_i);
  // R5
  filt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_q) |-> !stb_s_i);
endmodule

// File: rtl/rcg_guard.sv
module rcg_guard
  import rcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             stb_s_i,
  input  logic             mclr_s_i,
  input  logic             other_s_i,
  input  logic [CMD_W-1:0] stage_i,
  output relay_cmd_t       cmd_o,
  output logic             fault_o
);
  relay_cmd_t  cand, q_q, q_n;
  logic        fault_q, fault_n, valid;
  int unsigned n_in, n_out;

  assign cand.inl  = stage_i[OUT_LSB-1:IN_LSB];
  assign cand.outl = stage_i[CUR_BIT-1:OUT_LSB];
  assign cand.cur  = stage_i[CUR_BIT];

  always_comb begin
    n_in  = ones(cand.inl);
    n_out = ones(IN_N'(cand.outl));
    valid = (n_in <= 1) && (n_out <= 1) && !((n_out != 0) && other_s_i);
  end

  always_comb begin
    q_n     = q_q;
    fault_n = fault_q;
    if (load_i) begin
      if (valid) begin
        q_n     = cand;
        fault_n = 1'b0;
      end else begin
        fault_n = 1'b1;
      end
    end
    if ((q_q.outl != '0) && other_s_i) fault_n = 1'b1;
    if (!stb_s_i || fault_n || !mclr_s_i) q_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q     <= '0;
      fault_q <= 1'b0;
    end else begin
      q_q     <= q_n;
      fault_q <= fault_n;
    end
  end

  assign cmd_o   = q_q;
  assign fault_o = fault_q;

  // R3
  stb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_s_i |=> (cmd_o == '0));
  // R7
  one_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmd_o.inl) <= 1);
  // R8
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmd_o.outl) <= 1);
  // R10
  mclr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mclr_s_i |=> (cmd_o == '0));
  // R11
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (cmd_o == '0));
  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !load_i) |=> fault_o);
endmodule

// File: rtl/relay_cmd_guard.sv
module relay_cmd_guard
  import rcg_pkg::*;
#(
  parameter int SETTLE_CYC = 3_000_000,
  parameter int FILT_CYC   = 100_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  output logic             ser_dat_o,
  input  logic             latch_n_i,
  input  logic             mclr_n_i,
  input  logic             other_active_i,
  output logic             mclr_pull_o,
  output logic [IN_N-1:0]  in_relay_o,
  output logic [OUT_N-1:0] out_relay_o,
  output logic             cur_relay_o
);
  localparam int SYNC_W = 5;

  logic [SYNC_W-1:0] raw, syn;
  logic              sclk_s, sdi_s, stb_s, mclr_s, other_s;
  logic              load;
  logic [CMD_W-1:0]  stage;
  relay_cmd_t        cmd;

  assign raw = {other_active_i, mclr_n_i, latch_n_i, ser_dat_i, ser_clk_i};
  assign {other_s, mclr_s, stb_s, sdi_s, sclk_s} = syn;

  rcg_sync #(.W(SYNC_W), .RST_VAL(5'b01100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

  rcg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s_i(sclk_s), .sdi_s_i(sdi_s),
    .stb_s_i(stb_s), .sdo_o(ser_dat_o), .stage_o(stage));

  rcg_strobe_filter #(.SETTLE_CYC(SETTLE_CYC), .FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .stb_s_i(stb_s), .load_o(load));

  rcg_guard u_guard (
    .clk(clk), .rst_n(rst_n), .load_i(load), .stb_s_i(stb_s),
    .mclr_s_i(mclr_s), .other_s_i(other_s), .stage_i(stage),
    .cmd_o(cmd), .fault_o(mclr_pull_o));

  assign in_relay_o  = cmd.inl;
  assign out_relay_o = cmd.outl;
  assign cur_relay_o = cmd.cur;
endmodule

// File: tb/tb_relay_cmd_guard.sv
module tb_relay_cmd_guard;
  localparam int SET  = 40;
  localparam int FILT = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, stb = 1'b1, mclr_n = 1'b1, other = 1'b0;
  logic sdo, pull, cur;
  logic [9:0] inr;
  logic [3:0] outr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  relay_cmd_guard #(.SETTLE_CYC(SET), .FILT_CYC(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdi), .ser_dat_o(sdo),
    .latch_n_i(stb), .mclr_n_i(mclr_n), .other_active_i(other),
    .mclr_pull_o(pull), .in_relay_o(inr), .out_relay_o(outr), .cur_relay_o(cur));

  function automatic int pc(input logic [9:0] v);
    int n = 0;
    for (int i = 0; i < 10; i++) n += int'(v[i]);
    return n;
  endfunction

  // expected {pull, cur, out, in} after applying word w
  function automatic logic [15:0] model(input logic [23:0] w, input logic oth);
    logic bad;
    bad = (pc(w[9:0]) > 1) || (pc({6'd0, w[13:10]}) > 1) || ((w[13:10] != 0) && oth);
    return bad ? 16'h8000 : {1'b0, w[14], w[13:10], w[9:0]};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [15:0] exp);
    logic [15:0] act;
    act = {pull, cur, outr, inr};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic shift_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      sdi = w[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic send(input logic [23:0] w, input string tag);
    stb = 1'b0;
    wait_clk(FILT + 4);
    check("R3 strobe low clears", {pull, 15'd0});
    shift_word(w);
    stb = 1'b1;
    wait_clk(SET - 2);
    check("R4 not before settle", {pull, 15'd0});
    wait_clk(8);
    check(tag, model(w, other));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    logic [23:0] a, b;
    logic [15:0] keep;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    check("R3 reset state", 16'h0000);
    check_bit("R1 reset sdo", sdo, 1'b0);

    // R6 field sweep with reserved bits filled
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 4; j++) begin
        w = 24'(1) << i;
        w |= 24'(1) << (10 + j);
        w[14] = i[0];
        w[23:15] = 9'(i * 37 + j * 11 + 5);
        send(w, "R6 field map");
      end
    end
    // R8 every output-layer pattern
    for (int m = 0; m < 16; m++) begin
      w = {9'h1FF, 1'b1, 4'(m), 10'h004};
      send(w, (pc({6'd0, 4'(m)}) > 1) ? "R8 multi output" : "R6 output single");
    end
    // R7 input pairs
    for (int i = 0; i < 9; i++) begin
      w = (24'(3) << i) | 24'h000400;
      send(w, "R7 multi input");
      check_bit("R7 pull asserted", pull, 1'b1);
    end
    // R11 fault held then cleared by valid command
    send(24'h000C03, "R7 fault set");
    wait_clk(50);
    check("R11 fault held", 16'h8000);
    send(24'h000410, "R11 fault cleared");
    send(24'h000000, "R6 empty command");

    // R9 other card active
    other = 1'b1;
    send(24'h000801, "R9 output with other active");
    send(24'h004020, "R9 input only accepted");
    other = 1'b0;

    // R5 short strobe pulse
    send(24'h000802, "R5 setup");
    stb = 1'b0;
    wait_clk(2);
    stb = 1'b1;
    wait_clk(4);
    check("R5 short pulse clears", 16'h0000);
    wait_clk(SET + 20);
    check("R5 no reload", 16'h0000);

    // R2 serial edges ignored while strobe high
    send(24'h004440, "R2 setup");
    keep = {pull, cur, outr, inr};
    begin
      logic s0;
      s0 = sdo;
      for (int k = 0; k < 30; k++) begin
        sdi = k[0];
        wait_clk(3);
        sclk = 1'b1;
        wait_clk(3);
        sclk = 1'b0;
      end
      check("R2 outputs unchanged", keep);
      check_bit("R2 sdo unchanged", sdo, s0);
    end

    // R10 master clear
    send(24'h001008, "R10 setup");
    mclr_n = 1'b0;
    wait_clk(4);
    check("R10 clear drops outputs", 16'h0000);
    mclr_n = 1'b1;
    wait_clk(30);
    check("R10 stays off after release", 16'h0000);
    // R10 clear overlapping apply moment
    stb = 1'b0;
    wait_clk(FILT + 4);
    shift_word(24'h000402);
    mclr_n = 1'b0;
    stb = 1'b1;
    wait_clk(SET + 10);
    check("R10 apply during clear", 16'h0000);
    mclr_n = 1'b1;
    wait_clk(20);
    check("R10 no late apply", 16'h0000);

    // R1 daisy chain: first word appears on sdo while second shifts
    a = 24'hA5C3_96;
    b = 24'h004804;
    stb = 1'b0;
    wait_clk(FILT + 4);
    shift_word(a);
    for (int i = 23; i >= 0; i--) begin
      check_bit("R1 chained sdo", sdo, a[i]);
      sdi = b[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    stb = 1'b1;
    wait_clk(SET + 8);
    check("R1 second word applied", model(b, 1'b0));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule